// File: doc/BRIEF.md
# Slot Power Mode Controller

This block sits beside the three pass switches that feed a removable card slot: a main rail, a secondary rail and an auxiliary rail. From the slot's shutdown and standby requests, the two card-detect contacts, per-input undervoltage-lockout flags and a thermal-fault flag, it picks an operating mode each clock cycle. For every rail it then drives one of three output states: connected (pass switch on), floating (switch and pull-down both off) or grounded (discharge pull-down on).

The standby request depends on history. If standby arrives while a card is already seated, the auxiliary rail stays up. If standby is already active before any card is detected, the slot locks fully off, and it stays off even after a card arrives. The lock is released only by lifting standby. Losing the main or secondary input while a card is present removes only those two rails.

The block also combines the three per-switch over-current reports into one active-low fault flag for an open-drain pad. The flag only changes after the raw condition has held for a programmable number of cycles, in both directions.

Top module: `slot_power_ctrl`

## Requirements
- R1: A card is present when `cp_a_n` or `cp_b_n` is low. It is absent only when both contacts are high. Either contact alone is enough to power the slot.
- R2: While `shdn_n` is low (and the auxiliary input is not locked out), every rail settles to grounded: `sw_en` = 0 and `dis_en` = 1.
- R3: With no card present (and no higher-priority condition), every rail settles to grounded.
- R4: With a card present, `stby_n` low and no lock-off memory, the main and secondary rails float and the auxiliary rail stays connected.
- R5: If `stby_n` is low while no card is present, a lock-off memory is set. While the memory is set and `stby_n` stays low, all three rails float, even after a card is inserted. Raising `stby_n` clears the memory.
- R6: `uvlo[2]` (auxiliary input low) floats all three rails. This condition overrides every other input. The fixed priority, from highest to lowest, is: auxiliary lockout, shutdown, card absent, thermal fault, lock-off, standby, main/secondary lockout.
- R7: `uvlo[0]` (main) or `uvlo[1]` (secondary) floats both the main and the secondary rail and leaves the auxiliary rail connected.
- R8: `therm_fault` high with a card present floats all three rails until the flag clears.
- R9: With a card present and no other condition active, all three rails are connected.
- R10: Rail bit positions are 0 = main, 1 = secondary, 2 = auxiliary.
  - `sw_en[i]` and `dis_en[i]` are never both high.
  - A move between connected and grounded spends exactly one cycle floating.
  - Any other state change takes effect on the first clock edge after the input change.
- R11: `oc_flag_n` goes low only after the OR of `oc` has been high for `DEGLITCH_CYCLES` consecutive edges. It returns high only after that OR has been low for the same count. Any shorter excursion is ignored.
- R12: During and right after reset, all rails float (`sw_en` = 0, `dis_en` = 0), `oc_flag_n` = 1 and the lock-off memory is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shdn_n | input | 1 | Shutdown request, active low |
| stby_n | input | 1 | Standby request, active low |
| cp_a_n | input | 1 | Card-detect contact A, active low |
| cp_b_n | input | 1 | Card-detect contact B, active low |
| uvlo | input | 3 | Input undervoltage lockout per rail (bit 0 main, 1 secondary, 2 auxiliary) |
| oc | input | 3 | Raw over-current report per switch |
| therm_fault | input | 1 | Thermal fault, active high |
| sw_en | output | 3 | Pass-switch enable per rail |
| dis_en | output | 3 | Discharge pull-down enable per rail |
| oc_flag_n | output | 1 | Deglitched over-current flag, active low, for an open-drain pad |

## Verification
Most internal errors in this block show up at `sw_en` and `dis_en` within one or two clock edges. A wrong mode priority leaves a rail connected, floating or grounded where it should be in another state, and this is visible one edge after the input settles. A lock-off memory that sets or clears at the wrong time only shows up in a later step of a sequence: standby with no card, then insertion, then release. A missing float step shows up as a cycle with both enables high on one rail, or as a switch that rises straight out of discharge. A deglitch counter that is off by one shows up exactly `DEGLITCH_CYCLES` edges after `oc` changes, as an early or missing edge on `oc_flag_n`.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;

    localparam int NUM_RAILS = 3;
    localparam int RAIL_MAIN = 0;
    localparam int RAIL_SEC  = 1;
    localparam int RAIL_AUX  = 2;

    typedef enum logic [1:0] {
        RS_FLOAT   = 2'd0,
        RS_CONNECT = 2'd1,
        RS_GROUND  = 2'd2
    } rail_state_e;

    typedef enum logic [2:0] {
        M_UNPOWERED  = 3'd0,
        M_SHUTDOWN   = 3'd1,
        M_EMPTY      = 3'd2,
        M_THERMAL    = 3'd3,
        M_LOCKED_OFF = 3'd4,
        M_STANDBY    = 3'd5,
        M_AUX_ONLY   = 3'd6,
        M_ACTIVE     = 3'd7
    } slot_mode_e;

    typedef struct packed {
        logic                 shdn_n;
        logic                 stby_n;
        logic                 card;
        logic [NUM_RAILS-1:0] uvlo;
        logic                 therm;
    } slot_req_t;

    // Desired state of one rail in a given mode.
    function automatic rail_state_e rail_target(input slot_mode_e mode, input int rail);
        rail_state_e t;
        case (mode)
            M_UNPOWERED:  t = RS_FLOAT;
            M_SHUTDOWN:   t = RS_GROUND;
            M_EMPTY:      t = RS_GROUND;
            M_THERMAL:    t = RS_FLOAT;
            M_LOCKED_OFF: t = RS_FLOAT;
            M_STANDBY,
            M_AUX_ONLY:   t = (rail == RAIL_AUX) ? RS_CONNECT : RS_FLOAT;
            M_ACTIVE:     t = RS_CONNECT;
            default:      t = RS_FLOAT;
        endcase
        return t;
    endfunction

    // Next state with a one-cycle floating step between connect and ground.
    function automatic rail_state_e rail_step(input rail_state_e cur, input rail_state_e tgt);
        if (cur != tgt && cur != RS_FLOAT && tgt != RS_FLOAT)
            return RS_FLOAT;
        return tgt;
    endfunction

endpackage

// File: rtl/slot_mode_decoder.sv
module slot_mode_decoder
    import slot_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_req_t  req,
    output slot_mode_e mode
);

    logic off_mem;
    logic locked;

    // Remember a standby request that arrived while the slot was empty.
    always_ff @(posedge clk) begin
        if (rst)
            off_mem <= 1'b0;
        else if (req.stby_n)
            off_mem <= 1'b0;
        else if (!req.card)
            off_mem <= 1'b1;
    end

    assign locked = off_mem & ~req.stby_n;

    always_comb begin
        if (req.uvlo[RAIL_AUX])
            mode = M_UNPOWERED;
        else if (!req.shdn_n)
            mode = M_SHUTDOWN;
        else if (!req.card)
            mode = M_EMPTY;
        else if (req.therm)
            mode = M_THERMAL;
        else if (locked)
            mode = M_LOCKED_OFF;
        else if (!req.stby_n)
            mode = M_STANDBY;
        else if (req.uvlo[RAIL_MAIN] | req.uvlo[RAIL_SEC])
            mode = M_AUX_ONLY;
        else
            mode = M_ACTIVE;
    end

endmodule

// File: rtl/slot_rail_driver.sv
module slot_rail_driver
    import slot_pwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  rail_state_e target,
    output logic        sw_en,
    output logic        dis_en
);

    rail_state_e cur;

    always_ff @(posedge clk) begin
        if (rst)
            cur <= RS_FLOAT;
        else
            cur <= rail_step(cur, target);
    end

    assign sw_en  = (cur == RS_CONNECT);
    assign dis_en = (cur == RS_GROUND);

endmodule

// File: rtl/slot_oc_filter.sv
module slot_oc_filter #(
    parameter int unsigned DEGLITCH_CYCLES = 2_000_000,
    parameter int unsigned N_SRC           = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] oc_raw,
    output logic             oc_flag_n
);

    localparam int unsigned CW = $clog2(DEGLITCH_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEGLITCH_CYCLES - 1);

    logic          raw_any;
    logic          filt;
    logic [CW-1:0] cnt;

    assign raw_any = |oc_raw;

    // The count runs only while the raw level disagrees with the filtered one.
    always_ff @(posedge clk) begin
        if (rst) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (raw_any == filt) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            filt <= raw_any;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign oc_flag_n = ~filt;

endmodule

// File: rtl/slot_power_ctrl.sv
module slot_power_ctrl
    import slot_pwr_pkg::*;
#(
    parameter int unsigned DEGLITCH_CYCLES = 2_000_000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shdn_n,
    input  logic                 stby_n,
    input  logic                 cp_a_n,
    input  logic                 cp_b_n,
    input  logic [NUM_RAILS-1:0] uvlo,
    input  logic [NUM_RAILS-1:0] oc,
    input  logic                 therm_fault,
    output logic [NUM_RAILS-1:0] sw_en,
    output logic [NUM_RAILS-1:0] dis_en,
    output logic                 oc_flag_n
);

    slot_req_t  req;
    slot_mode_e mode;

    always_comb begin
        req.shdn_n = shdn_n;
        req.stby_n = stby_n;
        req.card   = ~(cp_a_n & cp_b_n);
        req.uvlo   = uvlo;
        req.therm  = therm_fault;
    end

    slot_mode_decoder u_mode (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .mode (mode)
    );

    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
        rail_state_e tgt;
        assign tgt = rail_target(mode, r);

        slot_rail_driver u_drv (
            .clk    (clk),
            .rst    (rst),
            .target (tgt),
            .sw_en  (sw_en[r]),
            .dis_en (dis_en[r])
        );
    end

    slot_oc_filter #(
        .DEGLITCH_CYCLES (DEGLITCH_CYCLES),
        .N_SRC           (NUM_RAILS)
    ) u_oc (
        .clk       (clk),
        .rst       (rst),
        .oc_raw    (oc),
        .oc_flag_n (oc_flag_n)
    );

endmodule

// File: rtl/slot_power_ctrl_checker.sv
module slot_power_ctrl_checker (
    input logic       clk,
    input logic       rst,
    input logic       shdn_n,
    input logic       stby_n,
    input logic       cp_a_n,
    input logic       cp_b_n,
    input logic [2:0] uvlo,
    input logic [2:0] oc,
    input logic       therm_fault,
    input logic [2:0] sw_en,
    input logic [2:0] dis_en,
    input logic       oc_flag_n
);

    assert_rail_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        (sw_en & dis_en) == 3'b000);

    assert_aux_lockout_float_R6: assert property (@(posedge clk) disable iff (rst)
        uvlo[2] |=> (sw_en == 3'b000 && dis_en == 3'b000));

    assert_shutdown_off_R2: assert property (@(posedge clk) disable iff (rst)
        !shdn_n |=> sw_en == 3'b000);

    assert_empty_off_R3: assert property (@(posedge clk) disable iff (rst)
        (cp_a_n && cp_b_n) |=> sw_en == 3'b000);

    assert_thermal_off_R8: assert property (@(posedge clk) disable iff (rst)
        therm_fault |=> sw_en == 3'b000);

    assert_main_lockout_R7: assert property (@(posedge clk) disable iff (rst)
        (uvlo[0] || uvlo[1]) |=> sw_en[1:0] == 2'b00);

    assert_flag_needs_fault_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(oc_flag_n) |-> $past(|oc));

    assert_flag_needs_clear_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(oc_flag_n) |-> !$past(|oc));

    for (genvar i = 0; i < 3; i++) begin : g_bbm
        assert_switch_from_float_R10: assert property (@(posedge clk) disable iff (rst)
            $rose(sw_en[i]) |-> !$past(dis_en[i]));
        assert_discharge_from_float_R10: assert property (@(posedge clk) disable iff (rst)
            $rose(dis_en[i]) |-> !$past(sw_en[i]));
    end

endmodule

bind slot_power_ctrl slot_power_ctrl_checker u_chk (.*);

// File: tb/slot_power_ctrl_test.sv
`timescale 1ns/1ps
module slot_power_ctrl_test;

    localparam int DG = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shdn_n = 1'b1, stby_n = 1'b1, cp_a_n = 1'b1, cp_b_n = 1'b1;
    logic [2:0] uvlo = 3'b000, oc = 3'b000;
    logic       therm_fault = 1'b0;
    logic [2:0] sw_en, dis_en;
    logic       oc_flag_n;

    int checks = 0;
    int fails  = 0;
    bit overlap_seen = 1'b0;

    always #5 clk = ~clk;

    slot_power_ctrl #(.DEGLITCH_CYCLES(DG)) uut (
        .clk(clk), .rst(rst), .shdn_n(shdn_n), .stby_n(stby_n),
        .cp_a_n(cp_a_n), .cp_b_n(cp_b_n), .uvlo(uvlo), .oc(oc),
        .therm_fault(therm_fault), .sw_en(sw_en), .dis_en(dis_en),
        .oc_flag_n(oc_flag_n)
    );

    always @(negedge clk)
        if (!rst && (sw_en & dis_en) != 3'b000) overlap_seen = 1'b1;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // {shdn_n, stby_n, cp_a_n, cp_b_n, uvlo[2:0], therm, 2'b0, sw[2:0], dis[2:0]}
    // rail bits: 0 main, 1 secondary, 2 auxiliary
    localparam int NV = 23;
    localparam logic [15:0] VEC [NV] = '{
        16'b1111_000_0_00_000_111, // R3 no card
        16'b1101_000_0_00_111_000, // R1 contact A, R9
        16'b1110_000_0_00_111_000, // R1 contact B
        16'b1100_000_0_00_111_000, // R1 both
        16'b1001_000_0_00_100_000, // R4 standby after insertion
        16'b1101_000_0_00_111_000, // R9 standby lifted
        16'b1101_001_0_00_100_000, // R7 main lockout
        16'b1101_010_0_00_100_000, // R7 secondary lockout
        16'b1101_100_0_00_000_000, // R6 aux lockout
        16'b1101_000_1_00_000_000, // R8 thermal
        16'b0101_000_0_00_000_111, // R2 shutdown with card
        16'b0101_100_0_00_000_000, // R6 aux lockout beats shutdown
        16'b1101_000_0_00_111_000, // R9 normal
        16'b1111_000_0_00_000_111, // R3 removal
        16'b1011_000_0_00_000_111, // R5 standby while empty
        16'b1001_000_0_00_000_000, // R5 insert while locked
        16'b1101_000_0_00_111_000, // R5 release clears
        16'b1001_000_0_00_100_000, // R4 standby after insertion again
        16'b1011_000_0_00_000_111, // R3 removal during standby
        16'b1001_000_0_00_000_000, // R5 reinsertion stays off
        16'b1101_000_0_00_111_000, // R5 release
        16'b0111_000_0_00_000_111, // R2 shutdown empty
        16'b1111_000_0_00_000_111  // R3 idle
    };

    initial begin
        // R12 reset state
        edges(3);
        check("R12 sw", {5'b0, sw_en}, 8'd0);
        check("R12 dis", {5'b0, dis_en}, 8'd0);
        check("R12 flag", {7'b0, oc_flag_n}, 8'd1);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            {shdn_n, stby_n, cp_a_n, cp_b_n, uvlo, therm_fault} = VEC[v][15:8];
            edges(3);
            check($sformatf("vec%0d sw", v), {5'b0, sw_en}, {5'b0, VEC[v][5:3]});
            check($sformatf("vec%0d dis", v), {5'b0, dis_en}, {5'b0, VEC[v][2:0]});
        end

        // R10 latency and float step: connected -> grounded
        {shdn_n, stby_n, cp_a_n, cp_b_n, uvlo, therm_fault} = 8'b1101_000_0;
        edges(3);
        shdn_n = 1'b0;
        edges(1);
        check("R10 float step sw", {5'b0, sw_en}, 8'd0);
        check("R10 float step dis", {5'b0, dis_en}, 8'd0);
        edges(1);
        check("R10 grounded", {5'b0, dis_en}, 8'b111);
        shdn_n = 1'b1;
        edges(1);
        check("R10 ground->float", {5'b0, sw_en, dis_en}, 8'd0);
        edges(1);
        check("R10 connected", {5'b0, sw_en}, 8'b111);
        therm_fault = 1'b1;
        edges(1);
        check("R10 one edge to float", {5'b0, sw_en}, 8'd0);
        therm_fault = 1'b0;
        edges(1);
        check("R10 one edge to connect", {5'b0, sw_en}, 8'b111);

        // R11 deglitch
        oc = 3'b010;
        edges(DG - 1);
        check("R11 short fault ignored", {7'b0, oc_flag_n}, 8'd1);
        oc = 3'b000;
        edges(2);
        oc = 3'b100;
        edges(DG - 1);
        check("R11 before count", {7'b0, oc_flag_n}, 8'd1);
        edges(1);
        check("R11 asserted", {7'b0, oc_flag_n}, 8'd0);
        oc = 3'b000;
        edges(DG - 1);
        check("R11 short clear ignored", {7'b0, oc_flag_n}, 8'd0);
        oc = 3'b001;
        edges(2);
        oc = 3'b000;
        edges(DG);
        check("R11 released", {7'b0, oc_flag_n}, 8'd1);

        check("R10 no overlap", {7'b0, overlap_seen}, 8'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule